// File: doc/BRIEF.md
# Two-Plane Planar Display Fetcher

This block builds a colour picture from image data that is kept as separate bitplanes. Each bitplane holds one bit of every pixel's colour index. A pixel's bits sit in different memory areas and are joined only when the pixel is shown. On every display line inside the vertical window, the block reads one 16-bit word per active plane for each 16-pixel group. It reads these from a word-wide synchronous memory, using a 32-bit byte pointer for each plane. It loads the words into per-plane shift registers and sends them out one bit per clock. The bits of the planes form a 2-bit index, which picks one of four 12-bit RGB palette entries.

Software or a coprocessor sets the block up through a write-only register port (word address plus data). The beam position comes from an external video timing generator, which advances `beam_x` once per clock. After the last read of a line, each plane pointer moves on by a signed line modulo. The pointers are never reloaded by the block, so the controlling agent must rewrite them for every frame.

Top module: `bitplane_fetcher`

## Requirements
- R1: After reset every register is zero, so `rgb` is 0x000, `disp_en` is low and `mem_rd` is low whatever the beam position.
- R2: On a line whose `beam_y` lies in [vstart, vstop), the block fetches in groups. Group g starts at x = fstart + 16*g, and only groups with that start <= fstop take part. In each group, plane 1 is read at the group start and plane 2 one clock later. `mem_addr` carries the plane pointer, and the pointer then advances by 2 bytes. At every other time `mem_rd` is low. Memory data returns one clock after the read.
- R3: A word read in group g is shown at x = fstart + 16*(g+1) + k, for k = 0..15, using bit 15-k (MSB first). Bit 0 of the pixel index comes from plane 1 and bit 1 from plane 2. Once the loaded data has been shifted out, the index is 0.
- R4: Mode register bits 14:12 give the plane count. A count of 0 means no reads and index 0. A count of 1 reads only plane 1, and index bit 1 is 0. A count of 2 or more reads both planes.
- R5: On each fetching line, two clocks after the last group's start, each active plane pointer adds its sign-extended 16-bit modulo. The odd modulo goes to plane 1 and the even modulo to plane 2.
- R6: Plane pointers change only through register writes (high half and low half separately), reads and modulo steps. Lines outside the vertical window and new frames leave them unchanged.
- R7: `disp_en` is high exactly when beam_x is in [hstart, hstop) and beam_y is in [vstart, vstop). Here the window-start register holds vstart in bits 15:8 and hstart in bits 7:0, and the window-stop register holds vstop and hstop in the same layout. Outside the window `rgb` equals palette entry 0.
- R8: Inside the window, `rgb` is palette[index] when mode bit 9 (colour enable) is 1, and palette entry 0 when it is 0.
- R9: Register word addresses are as follows. 0 is mode. 1 and 2 are window start and stop. 3 and 4 are fetch start and stop (bits 7:0 used). 5 is the odd modulo and 6 the even modulo. 8/9 are the plane 1 pointer high/low halves and 10/11 the plane 2 pointer high/low halves. 12 to 15 are palette entries 0 to 3 (bits 11:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| beam_x | input | 8 | Horizontal beam position |
| beam_y | input | 8 | Vertical beam position |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 16 | Memory read data, one clock after request |
| rgb | output | 12 | Pixel colour, 4 bits per component |
| disp_en | output | 1 | High inside the display window |

## Verification
A wrong pointer shows at once on `mem_addr` at the next fetch slot. If it is hidden there, it appears one line later, because a bad modulo step shifts every address on the following line. A stale or wrongly timed shift register produces a wrong colour in the first pixel group, 16 clocks after the fetch start. It also leaves non-zero indices after the last group where entry 0 is expected. Wrong window state shows on `disp_en` and `rgb` at the exact edge column or row.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 32;
  localparam int POS_W  = 8;
  localparam int NPL    = 2;
  localparam int REG_AW = 4;
  localparam int RGB_W  = 12;
  localparam int NPAL   = 1 << NPL;
  localparam int PH_W   = 4;
  localparam int CNT_W  = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MODE      = 4'd0,
    RA_WIN_FIRST = 4'd1,
    RA_WIN_LAST  = 4'd2,
    RA_FETCH_ON  = 4'd3,
    RA_FETCH_OFF = 4'd4,
    RA_STEP_ODD  = 4'd5,
    RA_STEP_EVEN = 4'd6
  } reg_sel_e;

  // half-open interval test used by the window logic
  function automatic logic in_span(input logic [POS_W-1:0] p,
                                   input logic [POS_W-1:0] lo,
                                   input logic [POS_W-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  // position inside the current 16-pixel fetch group
  function automatic logic [PH_W-1:0] slot_phase(input logic [POS_W-1:0] x,
                                                  input logic [POS_W-1:0] first);
    logic [POS_W-1:0] d;
    d = x - first;
    return d[PH_W-1:0];
  endfunction

  // pointer plus signed byte offset
  function automatic logic [PTR_W-1:0] add_step(input logic [PTR_W-1:0] p,
                                                input logic [WORD_W-1:0] s);
    return p + {{(PTR_W-WORD_W){s[WORD_W-1]}}, s};
  endfunction

  // plane count clamped to the implemented number of planes
  function automatic logic [CNT_W-1:0] eff_planes(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(NPL)) ? CNT_W'(NPL) : n;
  endfunction
endpackage

// File: rtl/bf_regs.sv
module bf_regs
  import bf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [REG_AW-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [CNT_W-1:0]              planes,
  output logic                          colour_en,
  output logic [WORD_W-1:0]             win_first,
  output logic [WORD_W-1:0]             win_last,
  output logic [POS_W-1:0]              fetch_on,
  output logic [POS_W-1:0]              fetch_off,
  output logic [WORD_W-1:0]             step_odd,
  output logic [WORD_W-1:0]             step_even,
  output logic [NPAL-1:0][RGB_W-1:0]    pal,
  output logic [NPL-1:0]                ptr_we_hi,
  output logic [NPL-1:0]                ptr_we_lo
);
  logic [CNT_W-1:0] planes_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      planes_raw <= '0;
      colour_en  <= 1'b0;
      win_first  <= '0;
      win_last   <= '0;
      fetch_on   <= '0;
      fetch_off  <= '0;
      step_odd   <= '0;
      step_even  <= '0;
    end else if (we) begin
      case (addr)
        RA_MODE: begin
          planes_raw <= wdata[14:12];
          colour_en  <= wdata[9];
        end
        RA_WIN_FIRST: win_first <= wdata;
        RA_WIN_LAST:  win_last  <= wdata;
        RA_FETCH_ON:  fetch_on  <= wdata[POS_W-1:0];
        RA_FETCH_OFF: fetch_off <= wdata[POS_W-1:0];
        RA_STEP_ODD:  step_odd  <= wdata;
        RA_STEP_EVEN: step_even <= wdata;
        default: ;
      endcase
    end
  end

  assign planes = eff_planes(planes_raw);

  // palette entries at the top quarter of the register space
  for (genvar e = 0; e < NPAL; e++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rst_n)
        pal[e] <= '0;
      else if (we && addr[3:2] == 2'b11 && addr[1:0] == 2'(e))
        pal[e] <= wdata[RGB_W-1:0];
    end
  end

  // pointer halves: address 8 + 2*plane (+1 for low half)
  for (genvar p = 0; p < NPL; p++) begin : g_ptr_dec
    assign ptr_we_hi[p] = we && addr[3:2] == 2'b10 && addr[1] == 1'(p) && !addr[0];
    assign ptr_we_lo[p] = we && addr[3:2] == 2'b10 && addr[1] == 1'(p) &&  addr[0];
  end
endmodule

// File: rtl/bf_fetch.sv
module bf_fetch
  import bf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [POS_W-1:0]            beam_x,
  input  logic [POS_W-1:0]            beam_y,
  input  logic [WORD_W-1:0]           win_first,
  input  logic [WORD_W-1:0]           win_last,
  input  logic [POS_W-1:0]            fetch_on,
  input  logic [POS_W-1:0]            fetch_off,
  input  logic [CNT_W-1:0]            planes,
  input  logic [WORD_W-1:0]           step_odd,
  input  logic [WORD_W-1:0]           step_even,
  input  logic [NPL-1:0]              ptr_we_hi,
  input  logic [NPL-1:0]              ptr_we_lo,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        mem_rd,
  output logic [PTR_W-1:0]            mem_addr,
  output logic [NPL-1:0][WORD_W-1:0]  hold,
  output logic [NPL-1:0][PTR_W-1:0]   ptr,
  output logic [NPL-1:0]              rd_ev,
  output logic                        eol_ev,
  output logic                        load_ev,
  output logic                        v_in
);
  logic [PH_W-1:0]  ph;
  logic [POS_W-1:0] grp_start;
  logic             slot_ok;
  logic             last_grp;
  logic [NPL-1:0]   rd_q;

  assign v_in      = in_span(beam_y, win_first[15:8], win_last[15:8]);
  assign ph        = slot_phase(beam_x, fetch_on);
  assign grp_start = beam_x - POS_W'(ph);
  assign slot_ok   = v_in && (planes != '0) && (beam_x >= fetch_on) &&
                     (grp_start <= fetch_off);
  assign last_grp  = ({1'b0, grp_start} + (POS_W+1)'(16)) > {1'b0, fetch_off};
  assign eol_ev    = slot_ok && last_grp && (ph == PH_W'(NPL));
  assign load_ev   = slot_ok && (ph == '1);

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [WORD_W-1:0] step;
    assign step     = (p % 2 == 0) ? step_odd : step_even;
    assign rd_ev[p] = slot_ok && (ph == PH_W'(p)) && (planes > CNT_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr[p]  <= '0;
        rd_q[p] <= 1'b0;
        hold[p] <= '0;
      end else begin
        rd_q[p] <= rd_ev[p];
        if (rd_q[p])
          hold[p] <= mem_rdata;
        if (ptr_we_hi[p])
          ptr[p][PTR_W-1:WORD_W] <= wdata;
        else if (ptr_we_lo[p])
          ptr[p][WORD_W-1:0] <= wdata;
        else if (rd_ev[p])
          ptr[p] <= ptr[p] + PTR_W'(2);
        else if (eol_ev && planes > CNT_W'(p))
          ptr[p] <= add_step(ptr[p], step);
      end
    end
  end

  always_comb begin
    mem_rd   = |rd_ev;
    mem_addr = ptr[0];
    for (int p = 0; p < NPL; p++)
      if (rd_ev[p]) mem_addr = ptr[p];
  end
endmodule

// File: rtl/bf_serial.sv
module bf_serial
  import bf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_ev,
  input  logic [CNT_W-1:0]            planes,
  input  logic [NPL-1:0][WORD_W-1:0]  hold,
  output logic [NPL-1:0]              idx
);
  for (genvar p = 0; p < NPL; p++) begin : g_shift
    logic [WORD_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n)
        sh <= '0;
      else if (load_ev)
        sh <= (planes > CNT_W'(p)) ? hold[p] : '0;
      else
        sh <= {sh[WORD_W-2:0], 1'b0};
    end
    assign idx[p] = sh[WORD_W-1];
  end
endmodule

// File: rtl/bf_colour.sv
module bf_colour
  import bf_pkg::*;
(
  input  logic [POS_W-1:0]           beam_x,
  input  logic                       v_in,
  input  logic [WORD_W-1:0]          win_first,
  input  logic [WORD_W-1:0]          win_last,
  input  logic                       colour_en,
  input  logic [NPL-1:0]             idx,
  input  logic [NPAL-1:0][RGB_W-1:0] pal,
  output logic [RGB_W-1:0]           rgb,
  output logic                       disp_en
);
  assign disp_en = v_in && in_span(beam_x, win_first[7:0], win_last[7:0]);
  assign rgb     = (disp_en && colour_en) ? pal[idx] : pal[0];
endmodule

// File: rtl/bitplane_fetcher.sv
module bitplane_fetcher
  import bf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic [POS_W-1:0]     beam_x,
  input  logic [POS_W-1:0]     beam_y,
  output logic                 mem_rd,
  output logic [PTR_W-1:0]     mem_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic [RGB_W-1:0]     rgb,
  output logic                 disp_en
);
  logic [CNT_W-1:0]            planes;
  logic                        colour_en;
  logic [WORD_W-1:0]           win_first, win_last, step_odd, step_even;
  logic [POS_W-1:0]            fetch_on, fetch_off;
  logic [NPAL-1:0][RGB_W-1:0]  pal;
  logic [NPL-1:0]              ptr_we_hi, ptr_we_lo;
  logic [NPL-1:0][WORD_W-1:0]  hold;
  logic [NPL-1:0][PTR_W-1:0]   ptr;
  logic [NPL-1:0]              rd_ev;
  logic                        eol_ev, load_ev, v_in;
  logic [NPL-1:0]              idx;

  bf_regs u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .planes, .colour_en, .win_first, .win_last, .fetch_on, .fetch_off,
    .step_odd, .step_even, .pal, .ptr_we_hi, .ptr_we_lo
  );

  bf_fetch u_fetch (
    .clk, .rst_n, .beam_x, .beam_y, .win_first, .win_last, .fetch_on,
    .fetch_off, .planes, .step_odd, .step_even, .ptr_we_hi, .ptr_we_lo,
    .wdata(reg_wdata), .mem_rdata, .mem_rd, .mem_addr, .hold, .ptr,
    .rd_ev, .eol_ev, .load_ev, .v_in
  );

  bf_serial u_serial (
    .clk, .rst_n, .load_ev, .planes, .hold, .idx
  );

  bf_colour u_colour (
    .beam_x, .v_in, .win_first, .win_last, .colour_en, .idx, .pal,
    .rgb, .disp_en
  );
endmodule

// File: rtl/bf_checker.sv
module bf_checker
  import bf_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mem_rd,
  input logic                       disp_en,
  input logic [RGB_W-1:0]           rgb,
  input logic [NPAL-1:0][RGB_W-1:0] pal,
  input logic                       colour_en,
  input logic [CNT_W-1:0]           planes,
  input logic                       v_in,
  input logic [NPL-1:0]             rd_ev,
  input logic                       eol_ev,
  input logic [NPL-1:0][PTR_W-1:0]  ptr,
  input logic [NPL-1:0]             ptr_we_hi,
  input logic [NPL-1:0]             ptr_we_lo,
  input logic [WORD_W-1:0]          step_odd
);
  a_r7_outside_pal0: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> rgb == pal[0]);

  a_r8_colour_off: assert property (@(posedge clk) disable iff (!rst_n)
    !colour_en |-> rgb == pal[0]);

  a_r2_read_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> v_in);

  a_r4_no_planes_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (planes == '0) |-> !mem_rd);

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev[0] && !ptr_we_hi[0] && !ptr_we_lo[0]) |=> ptr[0] == $past(ptr[0]) + PTR_W'(2));

  a_r5_modulo_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_ev && !ptr_we_hi[0] && !ptr_we_lo[0]) |=>
      ptr[0] == $past(ptr[0]) + {{(PTR_W-WORD_W){$past(step_odd[WORD_W-1])}}, $past(step_odd)});

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ev[0] && !eol_ev && !ptr_we_hi[0] && !ptr_we_lo[0]) |=> $stable(ptr[0]));
endmodule

bind bitplane_fetcher bf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .disp_en(disp_en), .rgb(rgb),
  .pal(pal), .colour_en(colour_en), .planes(planes), .v_in(v_in),
  .rd_ev(rd_ev), .eol_ev(eol_ev), .ptr(ptr), .ptr_we_hi(ptr_we_hi),
  .ptr_we_lo(ptr_we_lo), .step_odd(step_odd)
);

// File: tb/bitplane_fetcher_test.sv
module bitplane_fetcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  beam_x = 8'h7F;
  logic [7:0]  beam_y = 8'h00;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [11:0] rgb;
  logic        disp_en;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] mem [256];
  logic [11:0] m_pal [4];
  int          m_hs, m_ht, m_vs, m_vt, m_fs, m_ff, m_pl;
  logic        m_col;
  logic [15:0] m_mo, m_me;
  logic [31:0] m_p1, m_p2;

  // {planes, p1 g0, p1 g1, p2 g0, p2 g1}
  localparam logic [66:0] VEC [6] = '{
    {3'd2, 16'h8001, 16'hF00F, 16'hFF00, 16'h0F0F},
    {3'd2, 16'hAAAA, 16'h5555, 16'hCCCC, 16'h3333},
    {3'd1, 16'h1234, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {3'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {3'd3, 16'h0001, 16'h8000, 16'h8000, 16'h0001},
    {3'd2, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF}
  };

  always #10 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[8:1]];

  bitplane_fetcher uut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .beam_x, .beam_y,
    .mem_rd, .mem_addr, .mem_rdata, .rgb, .disp_en
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h at x=%0d y=%0d", tag, act, exp, beam_x, beam_y);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_mode(input int pl, input logic col);
    m_pl = (pl > 2) ? 2 : pl; m_col = col;
    wr(4'd0, 16'h8000 | 16'(pl << 12) | (col ? 16'h0200 : 16'h0000));
  endtask

  task automatic set_ptr(input logic [31:0] a1, input logic [31:0] a2);
    wr(4'd8, a1[31:16]); wr(4'd9, a1[15:0]);
    wr(4'd10, a2[31:16]); wr(4'd11, a2[15:0]);
    m_p1 = a1; m_p2 = a2;
  endtask

  task automatic set_step(input logic [15:0] o, input logic [15:0] e);
    wr(4'd5, o); wr(4'd6, e);
    m_mo = o; m_me = e;
  endtask

  task automatic run_line(input logic [7:0] y);
    logic [15:0] w1 [16];
    logic [15:0] w2 [16];
    int ng;
    logic vin;
    logic act;
    ng = 0;
    for (int g = 0; g < 16; g++)
      if (m_fs + 16*g <= m_ff && m_fs + 16*g < 256) ng = g + 1;
    for (int g = 0; g < 16; g++) begin
      w1[g] = mem[8'((m_p1 + 32'(2*g)) >> 1)];
      w2[g] = mem[8'((m_p2 + 32'(2*g)) >> 1)];
    end
    vin = (y >= m_vs) && (y < m_vt);
    act = vin && (m_pl > 0);
    for (int x = 0; x < 128; x++) begin
      logic        e_rd, e_de;
      logic [31:0] e_addr;
      logic [1:0]  e_idx;
      @(negedge clk);
      beam_x = 8'(x); beam_y = y;
      #5;
      e_rd = 1'b0; e_addr = '0; e_idx = 2'b00;
      if (act && x >= m_fs && (x - m_fs) / 16 < ng) begin
        if ((x - m_fs) % 16 == 0) begin e_rd = 1'b1; e_addr = m_p1 + 32'(2*((x - m_fs) / 16)); end
        if ((x - m_fs) % 16 == 1 && m_pl >= 2) begin e_rd = 1'b1; e_addr = m_p2 + 32'(2*((x - m_fs) / 16)); end
      end
      chk("R2 mem_rd", 32'(mem_rd), 32'(e_rd));
      if (e_rd) chk("R2/R6 mem_addr", mem_addr, e_addr);
      if (act && x >= m_fs + 16 && (x - m_fs - 16) / 16 < ng) begin
        int g, b;
        g = (x - m_fs - 16) / 16;
        b = 15 - (x - m_fs - 16) % 16;
        e_idx[0] = w1[g][b];
        e_idx[1] = (m_pl >= 2) ? w2[g][b] : 1'b0;
      end
      e_de = vin && x >= m_hs && x < m_ht;
      chk("R7 disp_en", 32'(disp_en), 32'(e_de));
      chk("R3/R4/R8 rgb", 32'(rgb), 32'((e_de && m_col) ? m_pal[e_idx] : m_pal[0]));
    end
    if (act) begin
      m_p1 = m_p1 + 32'(2*ng) + {{16{m_mo[15]}}, m_mo};
      if (m_pl >= 2) m_p2 = m_p2 + 32'(2*ng) + {{16{m_me[15]}}, m_me};
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101 ^ 16'h5A3C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, sampled at several beam positions
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      beam_x = 8'(k * 40); beam_y = 8'(k * 50);
      #5;
      chk("R1 rgb", 32'(rgb), 32'h0);
      chk("R1 disp_en", 32'(disp_en), 32'h0);
      chk("R1 mem_rd", 32'(mem_rd), 32'h0);
    end
    @(negedge clk); beam_x = 8'h7F; beam_y = 8'h00;

    // R9: configuration through the register map
    m_vs = 8'h10; m_hs = 8'h20; m_vt = 8'h20; m_ht = 8'h60;
    wr(4'd1, 16'h1020); wr(4'd2, 16'h2060);
    m_fs = 8'h10; m_ff = 8'h20;
    wr(4'd3, 16'hAB10); wr(4'd4, 16'hCD20);
    m_pal[0] = 12'h123; m_pal[1] = 12'hAAA; m_pal[2] = 12'hA00; m_pal[3] = 12'h0F0;
    for (int e = 0; e < 4; e++) wr(4'(12 + e), {4'hF, m_pal[e]});
    set_step(16'h0000, 16'h0000);

    // vector table: R3 bit order, R4 plane counts
    for (int v = 0; v < 6; v++) begin
      mem[8'h20] = VEC[v][63:48]; mem[8'h21] = VEC[v][47:32];
      mem[8'h40] = VEC[v][31:16]; mem[8'h41] = VEC[v][15:0];
      set_mode(int'(VEC[v][66:64]), 1'b1);
      set_ptr(32'h0000_0040, 32'h0000_0080);
      run_line(8'h12);
    end

    // R5: signed modulo, negative on plane 1, positive on plane 2
    set_mode(2, 1'b1);
    set_step(16'hFFFC, 16'h0004);
    set_ptr(32'h0000_0040, 32'h0000_0080);
    run_line(8'h12);
    run_line(8'h13);
    // R6: line outside vertical window leaves pointers alone
    run_line(8'h05);
    run_line(8'h14);
    // R6: new frame (rows restart) does not reload
    run_line(8'h1F);
    run_line(8'h10);
    // R6: high half of pointer written separately
    set_step(16'h0000, 16'h0000);
    set_ptr(32'h0003_0010, 32'h0001_00F0);
    run_line(8'h11);
    // R8: colour disabled shows entry 0 while window stays open
    set_mode(2, 1'b0);
    set_ptr(32'h0000_0040, 32'h0000_0080);
    run_line(8'h12);
    // R2: single fetch group when stop equals start
    set_mode(2, 1'b1);
    m_ff = 8'h10; wr(4'd4, 16'h0010);
    set_ptr(32'h0000_0060, 32'h0000_00A0);
    run_line(8'h15);
    // R7: last row of window is excluded
    run_line(8'h20);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule